// File: doc/BRIEF.md
# Precise Exception Sequencer

This block sits where instructions retire in a pipeline that completes in order, and decides when an exception is taken and where fetch resumes. It watches the oldest entry of the completion queue for fault conditions, and queue occupancy to tell when the queue has drained. It also latches asynchronous requests: system reset, machine check, external interrupt and decrementer. When it takes an exception it pulses a pipeline flush, saves the return address and the old machine state word, loads the vector address, records a cause code, and switches to supervisor mode with external interrupts disabled.

Only one exception is in service at a time, from entry until a return-from-exception. Reset and machine check are the exception: they are taken at once, even inside a handler and even with the queue busy. External and decrementer requests are noted the cycle they arrive. They wait until the completion queue is empty and software enables them. A return-from-exception restores the machine state from the state save register and redirects fetch to the saved return address.

Top module: `xcpt_sequencer`

## Requirements
- R1: After reset, the machine state reads 0x01 (bit 0 = supervisor set, bit 1 = interrupt enable clear). The in-handler flag, flush, fetch_go, save registers and cause all read zero.
- R2: When the queue head is valid (cq_valid bit 0), any head condition bit is set and no handler is active, the next cycle pulses flush and fetch_go. srr0 then holds the head address. The vector is 0x300 for condition 0 and the shared 0x700 for conditions 1 to 3, and the cause is 8 plus the condition index.
- R3: With several head condition bits set, the lowest index is taken alone. A remaining condition is taken after the handler returns.
- R4: Only the head entry can raise a synchronous exception, so condition bits with the head invalid are ignored. External and decrementer requests are never taken while any cq_valid bit is set.
- R5: Asynchronous priority is reset, then machine check, then external, then decrementer (async_req bits 0 to 3). They give cause 1/2/3/4 and vectors 0x100/0x200/0x500/0x900. srr0 is the head address if the head is valid and resume_pc otherwise.
- R6: External needs en_mask bit 0 and decrementer needs en_mask bit 1, and both need machine state bit 1. A masked request stays pending and is taken once enabled.
- R7: On entry, srr1 receives the old machine state. The new state is the old one with bit 0 set and bit 1 cleared, and in_handler becomes 1.
- R8: While in_handler is 1, synchronous, external and decrementer exceptions are held. Reset and machine check are still taken, and a simultaneous reset and machine check are taken on consecutive cycles.
- R9: rfi during a handler gives, next cycle, fetch_go without flush, fetch_pc = srr0, machine state = srr1 and in_handler = 0. rfi outside a handler has no effect.
- R10: msr_wr loads msr_wdata into the machine state. A same-cycle exception takes priority and discards the write.
- R11: A single-cycle external request that arrives while the queue is busy is remembered and taken in the cycle after the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cq_valid | input | CQ_DEPTH | Completion queue entry valid, bit 0 oldest |
| head_cond | input | NCOND | Fault conditions of the head entry |
| head_pc | input | ADDR_W | Address of the head entry |
| resume_pc | input | ADDR_W | Next fetch address when the queue is empty |
| async_req | input | 4 | Reset, machine check, external, decrementer requests |
| en_mask | input | 2 | Enable for external (bit 0) and decrementer (bit 1) |
| rfi | input | 1 | Return-from-exception |
| msr_wr | input | 1 | Machine state write strobe |
| msr_wdata | input | MSR_W | Machine state write data |
| flush | output | 1 | Flush all in-flight instructions |
| fetch_go | output | 1 | Fetch redirect strobe |
| fetch_pc | output | ADDR_W | Redirect address (vector or return address) |
| srr0 | output | ADDR_W | Saved return address |
| srr1 | output | MSR_W | Saved machine state |
| msr | output | MSR_W | Current machine state |
| cause | output | CAUSE_W | Cause code of the last exception taken |
| in_handler | output | 1 | An exception is in service |

## Verification
The assertions assume that the queue's head address is stable in the cycle an exception is taken. They also assume rfi is only meaningful while a handler runs, and that the surrounding pipeline empties cq_valid after a flush. The bench drives every input at the falling edge and samples one full cycle later. It clears the queue after each flush, and it applies a fresh reset before each sweep point, so that requests left pending from one point never reach the next. Both sweeps are exhaustive: all fifteen request mixes and all fifteen head condition mixes.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;
   // machine state bit positions
   localparam int MSR_SUP = 0;
   localparam int MSR_IE  = 1;

   // asynchronous source lanes, lowest lane has highest priority
   localparam int SRC_RESET = 0;
   localparam int SRC_MCHK  = 1;
   localparam int SRC_EXT   = 2;
   localparam int SRC_DEC   = 3;
   localparam int N_ASYNC   = 4;

   // vector slots, multiplied by the stride
   localparam int SLOT_RESET  = 1;
   localparam int SLOT_MCHK   = 2;
   localparam int SLOT_ACCESS = 3;
   localparam int SLOT_EXT    = 5;
   localparam int SLOT_PROG   = 7;
   localparam int SLOT_DEC    = 9;

   // cause codes
   localparam int CC_RESET     = 1;
   localparam int CC_MCHK      = 2;
   localparam int CC_EXT       = 3;
   localparam int CC_DEC       = 4;
   localparam int CC_SYNC_BASE = 8;

   function automatic int oh_to_idx(input logic [31:0] oh);
      int r;
      r = 0;
      for (int i = 0; i < 32; i++) begin
         if (oh[i]) r = r | i;
      end
      return r;
   endfunction
endpackage

// File: rtl/xcpt_prio_pick.sv
module xcpt_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N-1:0] lower_hit;

   initial begin
      assert (N >= 1 && N <= 32) else $error("xcpt_prio_pick: N out of range");
   end

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_lane
         if (g == 0) begin : g_first
            assign lower_hit[g] = 1'b0;
         end else begin : g_rest
            assign lower_hit[g] = |req[g-1:0];
         end
         assign grant[g] = req[g] & ~lower_hit[g];
      end
   endgenerate
endmodule

// File: rtl/xcpt_vector_map.sv
module xcpt_vector_map
   import xcpt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CAUSE_W = 5,
   parameter int CIDX_W = 2,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter int VEC_STRIDE = 'h100
) (
   input  logic              is_sync,
   input  logic [1:0]        async_idx,
   input  logic [CIDX_W-1:0] cond_idx,
   output logic [ADDR_W-1:0] vec,
   output logic [CAUSE_W-1:0] cause
);
   int slot;
   int code;

   always_comb begin
      slot = SLOT_RESET;
      code = CC_RESET;
      if (is_sync) begin
         slot = (cond_idx == '0) ? SLOT_ACCESS : SLOT_PROG;
         code = CC_SYNC_BASE + int'(cond_idx);
      end else begin
         case (async_idx)
            2'd0: begin slot = SLOT_RESET; code = CC_RESET; end
            2'd1: begin slot = SLOT_MCHK;  code = CC_MCHK;  end
            2'd2: begin slot = SLOT_EXT;   code = CC_EXT;   end
            default: begin slot = SLOT_DEC; code = CC_DEC;  end
         endcase
      end
   end

   assign vec   = VEC_BASE + ADDR_W'(slot * VEC_STRIDE);
   assign cause = CAUSE_W'(code);
endmodule

// File: rtl/xcpt_sequencer.sv
module xcpt_sequencer
   import xcpt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MSR_W    = 8,
   parameter int CQ_DEPTH = 4,
   parameter int NCOND    = 4,
   parameter int CAUSE_W  = 5,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter int VEC_STRIDE = 'h100,
   parameter logic [MSR_W-1:0] MSR_INIT = 'h1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CQ_DEPTH-1:0] cq_valid,
   input  logic [NCOND-1:0]    head_cond,
   input  logic [ADDR_W-1:0]   head_pc,
   input  logic [ADDR_W-1:0]   resume_pc,
   input  logic [3:0]          async_req,
   input  logic [1:0]          en_mask,
   input  logic                rfi,
   input  logic                msr_wr,
   input  logic [MSR_W-1:0]    msr_wdata,
   output logic                flush,
   output logic                fetch_go,
   output logic [ADDR_W-1:0]   fetch_pc,
   output logic [ADDR_W-1:0]   srr0,
   output logic [MSR_W-1:0]    srr1,
   output logic [MSR_W-1:0]    msr,
   output logic [CAUSE_W-1:0]  cause,
   output logic                in_handler
);
   localparam int CIDX_W = (NCOND > 1) ? $clog2(NCOND) : 1;

   initial begin
      assert (NCOND >= 1 && NCOND <= 32 && CQ_DEPTH >= 1 && MSR_W >= 2 &&
              ADDR_W >= 8 && (CC_SYNC_BASE + NCOND) <= (1 << CAUSE_W))
         else $error("xcpt_sequencer: parameter set out of range");
   end

   logic [N_ASYNC-1:0] pend_q, avail, elig, a_grant;
   logic [NCOND-1:0]   c_req, c_grant;
   logic               q_empty, sync_ok, take_hi, take, rfi_ok;
   logic [1:0]         a_idx;
   logic [CIDX_W-1:0]  c_idx;
   logic [ADDR_W-1:0]  vec, ret_addr;
   logic [CAUSE_W-1:0] code;
   logic [MSR_W-1:0]   msr_entry;

   assign q_empty = ~|cq_valid;
   assign avail   = pend_q | async_req;

   // eligibility: reset and machine check always; others wait for drain and enables
   always_comb begin
      elig            = '0;
      elig[SRC_RESET] = avail[SRC_RESET];
      elig[SRC_MCHK]  = avail[SRC_MCHK];
      elig[SRC_EXT]   = avail[SRC_EXT] & en_mask[0] & msr[MSR_IE] & q_empty & ~in_handler;
      elig[SRC_DEC]   = avail[SRC_DEC] & en_mask[1] & msr[MSR_IE] & q_empty & ~in_handler;
   end

   assign c_req   = cq_valid[0] ? head_cond : '0;
   assign sync_ok = (|c_req) & ~in_handler;
   assign take_hi = elig[SRC_RESET] | elig[SRC_MCHK];
   assign take    = take_hi | sync_ok | elig[SRC_EXT] | elig[SRC_DEC];
   assign rfi_ok  = rfi & in_handler & ~take;

   xcpt_prio_pick #(.N(N_ASYNC)) u_async_pick (.req(elig),  .grant(a_grant));
   xcpt_prio_pick #(.N(NCOND))   u_cond_pick  (.req(c_req), .grant(c_grant));

   assign a_idx = 2'(oh_to_idx(32'(a_grant)));
   assign c_idx = CIDX_W'(oh_to_idx(32'(c_grant)));

   xcpt_vector_map #(
      .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .CIDX_W(CIDX_W),
      .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_map (
      .is_sync(sync_ok & ~take_hi), .async_idx(a_idx), .cond_idx(c_idx),
      .vec(vec), .cause(code)
   );

   assign ret_addr = cq_valid[0] ? head_pc : resume_pc;

   always_comb begin
      msr_entry          = msr;
      msr_entry[MSR_SUP] = 1'b1;
      msr_entry[MSR_IE]  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= '0;
         flush      <= 1'b0;
         fetch_go   <= 1'b0;
         fetch_pc   <= '0;
         srr0       <= '0;
         srr1       <= '0;
         msr        <= MSR_INIT;
         cause      <= '0;
         in_handler <= 1'b0;
      end else begin
         pend_q   <= avail & ~a_grant;
         flush    <= take;
         fetch_go <= take | rfi_ok;
         if (take) begin
            fetch_pc   <= vec;
            srr0       <= ret_addr;
            srr1       <= msr;
            msr        <= msr_entry;
            cause      <= code;
            in_handler <= 1'b1;
         end else if (rfi_ok) begin
            fetch_pc   <= srr0;
            msr        <= srr1;
            in_handler <= 1'b0;
         end else if (msr_wr) begin
            msr <= msr_wdata;
         end
      end
   end

   AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (msr[MSR_SUP] && !msr[MSR_IE])); // R7
   AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (srr1 == $past(msr) && in_handler)); // R7
   AST_GO_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> fetch_go); // R2
   AST_SYNC_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && cause >= CAUSE_W'(CC_SYNC_BASE)) |-> ($past(cq_valid[0]) && srr0 == $past(head_pc))); // R4
   AST_ASYNC_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && (cause == CAUSE_W'(CC_EXT) || cause == CAUSE_W'(CC_DEC))) |-> $past(q_empty)); // R4
   AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && $past(in_handler)) |-> (cause == CAUSE_W'(CC_RESET) || cause == CAUSE_W'(CC_MCHK))); // R8
   AST_RFI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_go && !flush) |-> (msr == $past(srr1) && fetch_pc == $past(srr0) && !in_handler)); // R9
endmodule

// File: tb/xcpt_sequencer_bench.sv
`timescale 1ns/1ps
module xcpt_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cq_valid = '0;
   logic [3:0]  head_cond = '0;
   logic [31:0] head_pc = '0;
   logic [31:0] resume_pc = '0;
   logic [3:0]  async_req = '0;
   logic [1:0]  en_mask = '0;
   logic        rfi = 1'b0;
   logic        msr_wr = 1'b0;
   logic [7:0]  msr_wdata = '0;
   logic        flush, fetch_go, in_handler;
   logic [31:0] fetch_pc, srr0;
   logic [7:0]  srr1, msr;
   logic [4:0]  cause;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xcpt_sequencer u_xcpt_sequencer (
      .clk(clk), .rst_n(rst_n), .cq_valid(cq_valid), .head_cond(head_cond),
      .head_pc(head_pc), .resume_pc(resume_pc), .async_req(async_req),
      .en_mask(en_mask), .rfi(rfi), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
      .flush(flush), .fetch_go(fetch_go), .fetch_pc(fetch_pc), .srr0(srr0),
      .srr1(srr1), .msr(msr), .cause(cause), .in_handler(in_handler)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowbit(input int v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic int async_vec(input int i);
      case (i)
         0: return 'h100;
         1: return 'h200;
         2: return 'h500;
         default: return 'h900;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cq_valid = '0; head_cond = '0; head_pc = '0; resume_pc = '0;
      async_req = '0; en_mask = '0; rfi = 1'b0; msr_wr = 1'b0; msr_wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_msr(input logic [7:0] v);
      msr_wr = 1'b1; msr_wdata = v;
      @(negedge clk);
      msr_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 msr", msr, 32'h01);
      chk("R1 in_handler", in_handler, 0);
      chk("R1 flush", flush, 0);
      chk("R1 fetch_go", fetch_go, 0);
      chk("R1 srr0", srr0, 0);
      chk("R1 srr1", srr1, 0);
      chk("R1 cause", cause, 0);

      // R5 R7 R8: exhaustive sweep of asynchronous request mixes
      for (int c = 1; c < 16; c++) begin
         int f;
         do_reset();
         set_msr(8'h03);
         en_mask = 2'b11;
         resume_pc = 32'h4000 + 32'(c * 16);
         async_req = 4'(c);
         @(negedge clk);
         async_req = '0;
         f = lowbit(c);
         chk($sformatf("R5 flush mix=%0d", c), flush, 1);
         chk($sformatf("R5 cause mix=%0d", c), cause, 32'(f + 1));
         chk($sformatf("R5 vector mix=%0d", c), fetch_pc, 32'(async_vec(f)));
         chk($sformatf("R5 srr0 mix=%0d", c), srr0, resume_pc);
         chk($sformatf("R7 srr1 mix=%0d", c), srr1, 32'h03);
         chk($sformatf("R7 msr mix=%0d", c), msr, 32'h01);
         chk($sformatf("R7 in_handler mix=%0d", c), in_handler, 1);
         @(negedge clk);
         if (c[0] && c[1]) begin
            chk($sformatf("R8 preempt flush mix=%0d", c), flush, 1);
            chk($sformatf("R8 preempt cause mix=%0d", c), cause, 2);
            chk($sformatf("R8 preempt srr1 mix=%0d", c), srr1, 32'h01);
         end else begin
            chk($sformatf("R8 held mix=%0d", c), flush, 0);
         end
      end

      // R2 R3: exhaustive sweep of head condition mixes
      for (int p = 1; p < 16; p++) begin
         int f;
         do_reset();
         cq_valid = 4'b0001;
         head_pc = 32'h8000 + 32'(p * 4);
         head_cond = 4'(p);
         @(negedge clk);
         cq_valid = '0; head_cond = '0;
         f = lowbit(p);
         chk($sformatf("R2 flush cond=%0d", p), flush, 1);
         chk($sformatf("R3 cause cond=%0d", p), cause, 32'(8 + f));
         chk($sformatf("R2 vector cond=%0d", p), fetch_pc, (f == 0) ? 32'h300 : 32'h700);
         chk($sformatf("R2 srr0 cond=%0d", p), srr0, head_pc);
         @(negedge clk);
         chk($sformatf("R2 single pulse cond=%0d", p), flush, 0);
      end

      // R4: head invalid ignores conditions; async waits for drain (R11)
      do_reset();
      cq_valid = 4'b0110; head_cond = 4'b0011;
      @(negedge clk);
      chk("R4 head invalid", flush, 0);
      @(negedge clk);
      chk("R4 head invalid later", flush, 0);
      head_cond = '0;
      set_msr(8'h03);
      en_mask = 2'b11; resume_pc = 32'h5000;
      cq_valid = 4'b0100; async_req = 4'b0100;
      @(negedge clk);
      async_req = '0;
      chk("R4 ext held busy", flush, 0);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk("R11 still pending", flush, 0);
      end
      cq_valid = '0;
      @(negedge clk);
      chk("R11 taken after drain", flush, 1);
      chk("R11 cause", cause, 3);
      chk("R11 srr0", srr0, 32'h5000);

      // R6: decrementer masked by en_mask
      do_reset();
      set_msr(8'h03);
      en_mask = 2'b01; resume_pc = 32'h6000;
      async_req = 4'b1000;
      @(negedge clk);
      async_req = '0;
      chk("R6 dec masked", flush, 0);
      @(negedge clk);
      chk("R6 dec masked later", flush, 0);
      en_mask = 2'b11;
      @(negedge clk);
      chk("R6 dec enabled", flush, 1);
      chk("R6 dec cause", cause, 4);
      chk("R6 dec vector", fetch_pc, 32'h900);

      // R6 R10: external masked by state bit 1, then enabled by write
      do_reset();
      en_mask = 2'b11;
      async_req = 4'b0100;
      @(negedge clk);
      async_req = '0;
      chk("R6 ext masked by state", flush, 0);
      set_msr(8'h03);
      chk("R10 state written", msr, 32'h03);
      chk("R6 not yet taken", flush, 0);
      @(negedge clk);
      chk("R6 ext after enable", flush, 1);
      chk("R6 ext cause", cause, 3);

      // R3 R8 R9: sequential conditions with return
      do_reset();
      set_msr(8'h83);
      cq_valid = 4'b0001; head_pc = 32'h9000; head_cond = 4'b0110;
      @(negedge clk);
      chk("R3 first cause", cause, 9);
      chk("R3 first vector", fetch_pc, 32'h700);
      chk("R7 srr1 saved", srr1, 32'h83);
      chk("R7 msr entry", msr, 32'h81);
      @(negedge clk);
      chk("R8 sync held", flush, 0);
      @(negedge clk);
      chk("R8 sync held later", flush, 0);
      cq_valid = '0; head_cond = 4'b0100; rfi = 1'b1;
      @(negedge clk);
      rfi = 1'b0;
      chk("R9 fetch_go", fetch_go, 1);
      chk("R9 no flush", flush, 0);
      chk("R9 fetch_pc", fetch_pc, 32'h9000);
      chk("R9 msr restored", msr, 32'h83);
      chk("R9 in_handler", in_handler, 0);
      cq_valid = 4'b0001;
      @(negedge clk);
      cq_valid = '0; head_cond = '0;
      chk("R3 second flush", flush, 1);
      chk("R3 second cause", cause, 10);
      chk("R3 second srr1", srr1, 32'h83);

      // R9: rfi outside handler ignored
      do_reset();
      rfi = 1'b1;
      @(negedge clk);
      rfi = 1'b0;
      chk("R9 ignored fetch_go", fetch_go, 0);
      chk("R9 ignored msr", msr, 32'h01);

      // R10: exception beats a same-cycle write
      do_reset();
      msr_wr = 1'b1; msr_wdata = 8'hF3; async_req = 4'b0001;
      @(negedge clk);
      msr_wr = 1'b0; async_req = '0;
      chk("R10 write discarded", msr, 32'h01);
      chk("R10 srr1 old state", srr1, 32'h01);

      // R5 R8: machine check beats a head fault, saves head address
      do_reset();
      cq_valid = 4'b0001; head_pc = 32'hA000; head_cond = 4'b0001;
      async_req = 4'b0010;
      @(negedge clk);
      async_req = '0;
      chk("R5 mcheck cause", cause, 2);
      chk("R5 mcheck srr0 head", srr0, 32'hA000);
      chk("R5 mcheck vector", fetch_pc, 32'h200);
      @(negedge clk);
      chk("R8 head fault held", flush, 0);
      cq_valid = '0; head_cond = '0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule